// File: doc/BRIEF.md
# Pulse-Interval Forward-Link Bit Decoder

This block turns the demodulated carrier envelope of a reader-to-tag link into decoded data bits. It samples a one-bit envelope on every clock, where 1 means full carrier and 0 means a modulation pulse. Each symbol is measured as the number of samples from one rising envelope edge to the next. A symbol is a stretch of carrier followed by one short pulse. The pulse has the same width for both bit values, and only the carrier stretch varies.

A frame opens with a long low delimiter. Three symbols follow it. The first is a data-0 that produces no output. The second is a calibration symbol whose length equals one data-0 plus one data-1. The third is optional and calibrates the return link. The decision pivot is half the calibration count, rounded down, and it is learned again in every frame. Later symbols are compared against that pivot. The return-link count is made available to the backscatter rate logic.

A two-flop synchronizer sits in front of edge detection. Every event passes through the same delay, so the measured counts are exact.

Top module: `pie_fwd_decoder`

## Requirements
- R1: After reset, every output is 0.
- R2: When an envelope rise follows a low run of at least DELIM_MIN samples (default 8), `frame_start_o` pulses for one cycle and both calibration outputs clear to 0. A shorter low run while idle produces no output.
- R3: The second symbol after the delimiter sets `rtcal_o` to that symbol's length in samples, counted from rise to rise.
- R4: A data symbol whose length is at or below floor(`rtcal_o`/2) decodes as 0, and a longer one decodes as 1. `bit_valid_o` pulses for one cycle with the value on `bit_o`. `bit_o` is 0 whenever there is no strobe.
- R5: If the third symbol after the delimiter is longer than `rtcal_o`, its length is stored in `trcal_o` and no bit is produced. Otherwise it decodes as data and `trcal_o` stays 0.
- R6: While a frame is decoding data, if the carrier stays high for more than 4×`rtcal_o` samples after the rise that began the current symbol, `frame_end_o` pulses once. The block then ignores symbols until the next delimiter.
- R7: Length counters are CNT_W bits wide (default 12) and saturate at 4095 instead of wrapping, so a calibration symbol longer than that reads 4095.
- R8: An envelope sample reaches the outputs three clock edges after the edge that first samples it. The synchronizer does not change any measured count.
- R9: A delimiter detected in the middle of a frame takes priority over decoding. It restarts the frame, and the symbol it terminates produces no bit.
- R10: The first symbol after the delimiter produces no bit and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| env_i | input | 1 | Envelope sample: 1 for carrier, 0 for pulse |
| bit_valid_o | output | 1 | One-cycle strobe for a decoded bit |
| bit_o | output | 1 | Decoded bit value, valid with the strobe |
| rtcal_o | output | CNT_W | Measured receive-calibration length |
| trcal_o | output | CNT_W | Measured return-link calibration length, 0 if absent |
| frame_start_o | output | 1 | One-cycle pulse when a delimiter is accepted |
| frame_end_o | output | 1 | One-cycle pulse when the carrier-high timeout ends a frame |

## Verification
The hardest conditions to reach are the two ways a frame can be cut short. One is a delimiter that arrives in the middle of a frame and must win over the pending bit. The other is a calibration symbol longer than the counter can hold. The stimulus extends the final pulse of a data symbol into a full delimiter to exercise the first. For the second, it sends a calibration symbol of 4500 samples, which forces saturation, and then decodes bits against the clamped pivot. A behavioural model of the sample stream, delayed by the three-edge latency, predicts every output on every cycle.

// File: rtl/pie_rx_pkg.sv
package pie_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_RCAL = 3'd2,
        ST_OPT  = 3'd3,
        ST_DATA = 3'd4
    } rx_state_e;

    localparam int unsigned CNT_W_DEF     = 12;
    localparam int unsigned DELIM_MIN_DEF = 8;
    localparam int unsigned SYNC_DEF      = 2;

endpackage

// File: rtl/pie_sync_edge.sv
module pie_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic lvl_o,
    output logic rise_o
);
    // STAGES synchronizer flops plus one history flop for edge detection.
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/pie_sat_count.sv
module pie_sat_count #(
    parameter int unsigned W        = 12,
    parameter int unsigned LOAD_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP  = '1;
    localparam logic [W-1:0] LVAL = W'(LOAD_VAL);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)            cnt_d = LVAL;
        else if (cnt_q == TOP) cnt_d = cnt_q;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pie_fwd_decoder.sv
module pie_fwd_decoder
    import pie_rx_pkg::*;
#(
    parameter int unsigned CNT_W       = CNT_W_DEF,
    parameter int unsigned DELIM_MIN   = DELIM_MIN_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             env_i,
    output logic             bit_valid_o,
    output logic             bit_o,
    output logic [CNT_W-1:0] rtcal_o,
    output logic [CNT_W-1:0] trcal_o,
    output logic             frame_start_o,
    output logic             frame_end_o
);
    localparam int unsigned END_SHIFT = 2;
    localparam int unsigned LIM_W     = CNT_W + END_SHIFT;
    localparam logic [CNT_W-1:0] DELIM_CNT = CNT_W'(DELIM_MIN);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] rcal;
        logic [CNT_W-1:0] tcal;
        logic             vld;
        logic             val;
        logic             fs;
        logic             fe;
    } regs_t;

    logic             env_lvl, env_rise;
    logic [CNT_W-1:0] sym_cnt, low_cnt;
    logic [CNT_W-1:0] pivot;
    logic [LIM_W-1:0] end_lim, sym_ext;
    logic             delim_seen, high_timeout;
    regs_t            r_d, r_q;

    pie_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (env_i),
        .lvl_o  (env_lvl),
        .rise_o (env_rise)
    );

    // Samples since the last rise; a rise restarts it at 1.
    pie_sat_count #(.W(CNT_W), .LOAD_VAL(1)) u_sym_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (env_rise),
        .cnt_o  (sym_cnt)
    );

    // Length of the current low run; carrier clears it.
    pie_sat_count #(.W(CNT_W), .LOAD_VAL(0)) u_low_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (env_lvl),
        .cnt_o  (low_cnt)
    );

    always_comb begin
        pivot        = r_q.rcal >> 1;
        end_lim      = {r_q.rcal, {END_SHIFT{1'b0}}};
        sym_ext      = {{END_SHIFT{1'b0}}, sym_cnt};
        delim_seen   = env_rise && (low_cnt >= DELIM_CNT);
        high_timeout = env_lvl && !env_rise && (sym_ext > end_lim);

        r_d     = r_q;
        r_d.vld = 1'b0;
        r_d.val = 1'b0;
        r_d.fs  = 1'b0;
        r_d.fe  = 1'b0;

        if (delim_seen) begin
            r_d.st   = ST_LEAD;
            r_d.rcal = '0;
            r_d.tcal = '0;
            r_d.fs   = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_IDLE: ;
                ST_LEAD: if (env_rise) r_d.st = ST_RCAL;
                ST_RCAL: begin
                    if (env_rise) begin
                        r_d.rcal = sym_cnt;
                        r_d.st   = ST_OPT;
                    end
                end
                ST_OPT, ST_DATA: begin
                    if (env_rise) begin
                        r_d.st = ST_DATA;
                        if (r_q.st == ST_OPT && sym_cnt > r_q.rcal) begin
                            r_d.tcal = sym_cnt;
                        end else begin
                            r_d.vld = 1'b1;
                            r_d.val = (sym_cnt > pivot);
                        end
                    end else if (high_timeout) begin
                        r_d.fe = 1'b1;
                        r_d.st = ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, rcal: '0, tcal: '0, vld: 1'b0,
                     val: 1'b0, fs: 1'b0, fe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_valid_o   = r_q.vld;
    assign bit_o         = r_q.val;
    assign rtcal_o       = r_q.rcal;
    assign trcal_o       = r_q.tcal;
    assign frame_start_o = r_q.fs;
    assign frame_end_o   = r_q.fe;
endmodule

// File: rtl/pie_fwd_decoder_chk.sv
module pie_fwd_decoder_chk #(
    parameter int unsigned CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid_o,
    input logic             bit_o,
    input logic [CNT_W-1:0] rtcal_o,
    input logic [CNT_W-1:0] trcal_o,
    input logic             frame_start_o,
    input logic             frame_end_o
);
    // R4: a decoded value appears only together with its strobe.
    a_r4_bit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o |-> bit_valid_o);

    // R2: an accepted delimiter clears both calibration counts.
    a_r2_start_clears_cal: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (rtcal_o == '0 && trcal_o == '0));

    // R2: a delimiter needs a long low run, so starts never come back to back.
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);

    // R6: a frame end carries no bit and no start.
    a_r6_end_alone: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |-> (!bit_valid_o && !frame_start_o));

    // R3: the pivot source stays put while bits are being emitted.
    a_r3_cal_stable_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> $stable(rtcal_o));

    // R5: a newly captured return-link count is always above the receive count.
    a_r5_trcal_above_rtcal: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start_o && !$stable(trcal_o)) |-> (trcal_o > rtcal_o));
endmodule

bind pie_fwd_decoder pie_fwd_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_valid_o   (bit_valid_o),
    .bit_o         (bit_o),
    .rtcal_o       (rtcal_o),
    .trcal_o       (trcal_o),
    .frame_start_o (frame_start_o),
    .frame_end_o   (frame_end_o)
);

// File: tb/pie_fwd_decoder_bench.sv
`timescale 1ns/1ps
module pie_fwd_decoder_bench;
    localparam int DELIM = 8;
    localparam int SATV  = 4095;

    typedef struct packed {
        logic        fs;
        logic        fe;
        logic        bv;
        logic        b;
        logic [11:0] rc;
        logic [11:0] tc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        env = 1'b1;
    logic        bit_valid, bit_val, fstart, fend;
    logic [11:0] rtcal, trcal;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    exp_t q[$];

    // behavioural reference state
    int m_state = 0; // 0 idle, 1 lead, 2 rcal, 3 opt, 4 data
    int m_prev = 1;
    int m_cnt = 0;
    int m_low = 0;
    int m_rc = 0;
    int m_tc = 0;

    always #10 clk = ~clk;

    pie_fwd_decoder u_pie_fwd_decoder (
        .clk           (clk),
        .rst_n         (rst_n),
        .env_i         (env),
        .bit_valid_o   (bit_valid),
        .bit_o         (bit_val),
        .rtcal_o       (rtcal),
        .trcal_o       (trcal),
        .frame_start_o (fstart),
        .frame_end_o   (fend)
    );

    function automatic exp_t model(input int v);
        exp_t e;
        int   rise;
        e = '0;
        rise = (v == 1 && m_prev == 0) ? 1 : 0;
        if (rise == 1 && m_low >= DELIM) begin
            // R2 / R9: delimiter wins in every state
            e.fs = 1'b1; m_state = 1; m_rc = 0; m_tc = 0;
        end else if (m_state == 1) begin
            if (rise == 1) m_state = 2; // R10: leading data-0 is silent
        end else if (m_state == 2) begin
            if (rise == 1) begin m_rc = m_cnt; m_state = 3; end
        end else if (m_state >= 3) begin
            if (rise == 1) begin
                if (m_state == 3 && m_cnt > m_rc) m_tc = m_cnt;
                else begin e.bv = 1'b1; e.b = (m_cnt > m_rc / 2); end
                m_state = 4;
            end else if (v == 1 && m_cnt > 4 * m_rc) begin
                e.fe = 1'b1; m_state = 0; // R6
            end
        end
        m_cnt  = (rise == 1) ? 1 : ((m_cnt < SATV) ? m_cnt + 1 : SATV);
        m_low  = (v == 1) ? 0 : ((m_low < SATV) ? m_low + 1 : SATV);
        m_prev = v;
        e.rc = 12'(m_rc);
        e.tc = 12'(m_tc);
        return e;
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (fstart !== e.fs || fend !== e.fe) begin
            bad++;
            $display("FAIL R2/R6/R9 frame flags actual=%b%b expected=%b%b (R8 latency)",
                     fstart, fend, e.fs, e.fe);
        end
        checks++;
        if (bit_valid !== e.bv || bit_val !== e.b) begin
            bad++;
            $display("FAIL R4 bit actual=%b/%b expected=%b/%b", bit_valid, bit_val, e.bv, e.b);
        end
        checks++;
        if (rtcal !== e.rc) begin
            bad++;
            $display("FAIL R3 rtcal actual=%0d expected=%0d", rtcal, e.rc);
        end
        checks++;
        if (trcal !== e.tc) begin
            bad++;
            $display("FAIL R5 trcal actual=%0d expected=%0d", trcal, e.tc);
        end
    endtask

    task automatic step(input logic v);
        exp_t e;
        @(negedge clk);
        if (q.size() == 3) begin
            e = q.pop_front();
            compare(e);
        end
        env = v;
        q.push_back(model(v ? 1 : 0));
    endtask

    task automatic highs(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic lows(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic sym(input int h, input int l);
        highs(h);
        lows(l);
    endtask

    task automatic check_val(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        exp_t z;
        z = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check_val("R1 outputs after reset",
                  {bit_valid, bit_val, fstart, fend, rtcal, trcal}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) q.push_back(z);

        highs(20);
        // R2: short low run while idle is ignored
        sym(6, 4);
        highs(10);

        // Frame A: rtcal 20 (pivot 10), trcal 33, bits 0 1 0 1, timeout end
        lows(12);
        sym(5, 3);   // R10 data-0
        sym(17, 3);  // R3 rtcal = 20
        sym(30, 3);  // R5 trcal = 33
        sym(7, 3);   // 10 -> 0 (at pivot)
        sym(8, 3);   // 11 -> 1
        sym(5, 3);   // 8  -> 0
        sym(13, 3);  // 16 -> 1
        highs(100);  // R6 timeout after 80
        check_val("R3 rtcal after frame A", rtcal, 20);
        check_val("R5 trcal after frame A", trcal, 33);
        sym(5, 3);   // ignored after end
        sym(6, 3);
        highs(10);

        // Frame B: no trcal, then a delimiter mid-frame
        lows(10);
        sym(5, 3);
        sym(21, 3);  // rtcal 24, pivot 12
        sym(9, 3);   // 12 -> 0, not trcal
        sym(10, 3);  // 13 -> 1
        sym(21, 3);  // 24 -> 1
        sym(5, 3);   // R9: its low grows into a delimiter
        lows(10);

        // Frame C: saturating calibration
        sym(5, 3);
        sym(4497, 3); // R7 clamps to 4095
        sym(3000, 3); // 3003 > 2047 -> 1
        sym(1000, 3); // 1003 -> 0
        highs(10);
        check_val("R7 saturated rtcal", rtcal, SATV);
        check_val("R5 trcal absent", trcal, 0);
        lows(10);
        highs(10);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule